// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the multi-cycle control that moves a 16-bit processor into an interrupt handler and back out of it. It holds the program counter, the processor status word, the live stack pointer and the two parked stack pointers, one for the user stack and one for the supervisor stack. A request is taken only at an instruction boundary, and only when its level is above the running priority. On entry the block switches to the supervisor stack if the machine was in user mode. It saves the status word and the program counter there, sets up a fresh status word, and fetches the handler address from a vector table in memory.

A return request undoes this. The saved program counter and status word come back off the supervisor stack. If the restored status word says user mode, the supervisor pointer is parked again and the user pointer becomes the live one. All memory traffic goes through one simple port. Reads are combinational, and the data is captured at the clock edge that ends the read cycle.

Status word layout: bit 15 is the privilege bit (1 = user, 0 = supervisor), bits 10:8 hold the priority level, and bits 2:0 hold the N, Z and P condition codes.

Top module: `irq_seq_top`

## Requirements
- R1: After reset, pcOut = RESET_PC, psrOut = RESET_PSR, spOut = RESET_USP, savedSspOut = RESET_SSP, savedUspOut = 0, and busy and ackPulse are low.
- R2: A request is accepted only when the block is idle and, in the same cycle, fetchStart and irqValid are high and irqLevel is greater than psrOut[10:8]. In any other case, pcOut, psrOut and spOut do not change and busy stays low.
- R3: ackPulse is high for exactly one cycle, the cycle after the accepting edge. irqVector is sampled at the edge that ends that cycle, and later changes to it have no effect.
- R4: When the request is accepted in user mode (psrOut[15] = 1), savedUspOut takes the live stack pointer and spOut takes savedSspOut.
- R5: When the request is accepted in supervisor mode (psrOut[15] = 0), the stack pointer is not swapped and savedUspOut is unchanged.
- R6: Entry writes the old status word to address sp-1 and then the old program counter to sp-2, using pre-decrement. Each write leaves spOut equal to the address just written.
- R7: After entry, psrOut = {1'b0, 4'b0, level, 8'b0}: supervisor mode, the accepted level in bits 10:8, and condition codes 000.
- R8: After entry, pcOut holds the word read from address 16'h0100 + zero-extended vector. busy is high for the four cycles that follow the accepting edge and low from the fifth.
- R9: A return request in the idle state reads pcOut from address sp and psrOut from address sp+1, and leaves spOut at sp+2. busy is high for the three cycles after the accepting edge.
- R10: If the restored psrOut[15] is 1, savedSspOut takes the live pointer and spOut takes savedUspOut. If it is 0, no swap takes place.
- R11: memWrEn and memRdEn are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchStart | input | 1 | Instruction boundary marker |
| irqValid | input | 1 | Interrupt request present |
| irqLevel | input | 3 | Priority level of the request |
| irqVector | input | 8 | Vector number of the request, sampled after the acknowledge |
| rtiReq | input | 1 | Return-from-interrupt request |
| ackPulse | output | 1 | One-cycle acknowledge to the requester |
| busy | output | 1 | Sequence in progress |
| memAddr | output | 16 | Memory address |
| memWrEn | output | 1 | Memory write strobe |
| memRdEn | output | 1 | Memory read strobe |
| memWData | output | 16 | Memory write data |
| memRData | input | 16 | Memory read data, combinational |
| pcOut | output | 16 | Program counter |
| psrOut | output | 16 | Processor status word |
| spOut | output | 16 | Live stack pointer |
| savedUspOut | output | 16 | Parked user stack pointer |
| savedSspOut | output | 16 | Parked supervisor stack pointer |

## Verification
The accepting edge is the reference point. The acknowledge is due one cycle after it. The handler PC, new status word, stack pointers and stack contents are due four cycles after it, and a return completes three cycles after its accepting edge. The bench drives inputs on the falling edge and waits exactly that many falling edges before sampling. It also changes the vector right after the acknowledge edge, which checks that the vector is sampled in the right cycle. Requests that are refused are held for two cycles, and the bench then confirms that busy, the PC and the stack pointer did not move.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int WORD_W   = 16;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam int PRIV_BIT = 15;
  localparam int PRI_LO   = 8;
  localparam int CC_W     = 3;
  localparam logic [WORD_W-VEC_W-1:0] VEC_PAGE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACK, ST_PUSH_PSR, ST_PUSH_PC, ST_VEC_RD,
    ST_POP_PC, ST_POP_PSR, ST_RET_SWAP
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic sampleVec;
    logic swapIn;
    logic pushPsr;
    logic pushPc;
    logic loadVec;
    logic popPc;
    logic popPsr;
    logic swapOut;
  } seqStrobe_t;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchStart,
  input  logic             irqValid,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic             rtiReq,
  input  logic [LVL_W-1:0] curPri,
  input  logic             curUser,
  output seqStrobe_t       strobe,
  output logic             ackPulse,
  output logic             busy
);
  seqState_t state, stateNext;
  logic accept;

  assign accept = fetchStart && irqValid && (irqLevel > curPri);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          strobe.latchReq = 1'b1;
          stateNext = ST_ACK;
        end else if (rtiReq) begin
          stateNext = ST_POP_PC;
        end
      end
      ST_ACK: begin
        strobe.sampleVec = 1'b1;
        strobe.swapIn    = curUser;
        stateNext = ST_PUSH_PSR;
      end
      ST_PUSH_PSR: begin
        strobe.pushPsr = 1'b1;
        stateNext = ST_PUSH_PC;
      end
      ST_PUSH_PC: begin
        strobe.pushPc = 1'b1;
        stateNext = ST_VEC_RD;
      end
      ST_VEC_RD: begin
        strobe.loadVec = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_POP_PC: begin
        strobe.popPc = 1'b1;
        stateNext = ST_POP_PSR;
      end
      ST_POP_PSR: begin
        strobe.popPsr = 1'b1;
        stateNext = ST_RET_SWAP;
      end
      ST_RET_SWAP: begin
        strobe.swapOut = curUser;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign ackPulse = (state == ST_ACK);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC  = 16'h3000,
  parameter logic [WORD_W-1:0] RESET_PSR = 16'h8002,
  parameter logic [WORD_W-1:0] RESET_USP = 16'hFE00,
  parameter logic [WORD_W-1:0] RESET_SSP = 16'h1200
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic [VEC_W-1:0]  irqVector,
  input  logic [WORD_W-1:0] memRData,
  output logic [WORD_W-1:0] memAddr,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [WORD_W-1:0] memWData,
  output logic [WORD_W-1:0] pcQ,
  output logic [WORD_W-1:0] psrQ,
  output logic [WORD_W-1:0] spQ,
  output logic [WORD_W-1:0] uspQ,
  output logic [WORD_W-1:0] sspQ
);
  logic [LVL_W-1:0]  lvlQ;
  logic [VEC_W-1:0]  vecQ;
  logic [WORD_W-1:0] spDec, spInc, entryPsr;

  assign spDec = spQ - 16'd1;
  assign spInc = spQ + 16'd1;

  always_comb begin
    entryPsr = '0;
    entryPsr[PRI_LO +: LVL_W] = lvlQ;
  end

  always_comb begin
    memAddr = spQ;
    if (strobe.pushPsr || strobe.pushPc) memAddr = spDec;
    else if (strobe.loadVec)             memAddr = {VEC_PAGE, vecQ};
  end

  assign memWrEn  = strobe.pushPsr | strobe.pushPc;
  assign memRdEn  = strobe.loadVec | strobe.popPc | strobe.popPsr;
  assign memWData = strobe.pushPsr ? psrQ : pcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= RESET_PC;
      psrQ <= RESET_PSR;
      spQ  <= RESET_USP;
      uspQ <= '0;
      sspQ <= RESET_SSP;
      lvlQ <= '0;
      vecQ <= '0;
    end else begin
      if (strobe.latchReq)  lvlQ <= irqLevel;
      if (strobe.sampleVec) vecQ <= irqVector;
      if (strobe.swapIn) begin
        uspQ <= spQ;
        spQ  <= sspQ;
      end
      if (strobe.pushPsr) spQ <= spDec;
      if (strobe.pushPc) begin
        spQ  <= spDec;
        psrQ <= entryPsr;
      end
      if (strobe.loadVec) pcQ <= memRData;
      if (strobe.popPc) begin
        pcQ <= memRData;
        spQ <= spInc;
      end
      if (strobe.popPsr) begin
        psrQ <= memRData;
        spQ  <= spInc;
      end
      if (strobe.swapOut) begin
        sspQ <= spQ;
        spQ  <= uspQ;
      end
    end
  end
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter logic [15:0] RESET_PC  = 16'h3000,
  parameter logic [15:0] RESET_PSR = 16'h8002,
  parameter logic [15:0] RESET_USP = 16'hFE00,
  parameter logic [15:0] RESET_SSP = 16'h1200
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchStart,
  input  logic        irqValid,
  input  logic [2:0]  irqLevel,
  input  logic [7:0]  irqVector,
  input  logic        rtiReq,
  output logic        ackPulse,
  output logic        busy,
  output logic [15:0] memAddr,
  output logic        memWrEn,
  output logic        memRdEn,
  output logic [15:0] memWData,
  input  logic [15:0] memRData,
  output logic [15:0] pcOut,
  output logic [15:0] psrOut,
  output logic [15:0] spOut,
  output logic [15:0] savedUspOut,
  output logic [15:0] savedSspOut
);
  seqStrobe_t strobe;

  irq_seq_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .fetchStart(fetchStart), .irqValid(irqValid),
    .irqLevel(irqLevel), .rtiReq(rtiReq),
    .curPri(psrOut[PRI_LO +: LVL_W]), .curUser(psrOut[PRIV_BIT]),
    .strobe(strobe), .ackPulse(ackPulse), .busy(busy)
  );

  irq_seq_dp #(
    .RESET_PC(RESET_PC), .RESET_PSR(RESET_PSR),
    .RESET_USP(RESET_USP), .RESET_SSP(RESET_SSP)
  ) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqLevel(irqLevel),
    .irqVector(irqVector), .memRData(memRData), .memAddr(memAddr),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memWData(memWData),
    .pcQ(pcOut), .psrQ(psrOut), .spQ(spOut), .uspQ(savedUspOut),
    .sspQ(savedSspOut)
  );
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        fetchStart,
  input logic        ackPulse,
  input logic        busy,
  input logic        memWrEn,
  input logic        memRdEn,
  input logic [15:0] memAddr,
  input logic [15:0] spOut
);
  // R3
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> !ackPulse);
  // R2
  ack_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackPulse) |-> $past(fetchStart) && !$past(busy));
  // R6
  push_predec_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> spOut == $past(memAddr));
  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));
endmodule

bind irq_seq_top irq_seq_chk chkI (
  .clk(clk), .rstN(rstN), .fetchStart(fetchStart), .ackPulse(ackPulse),
  .busy(busy), .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
  .spOut(spOut)
);

// File: tb/irq_seq_top_tb_top.sv
module irq_seq_top_tb_top;
  localparam logic [15:0] R_PC = 16'h3000, R_PSR = 16'h8002;
  localparam logic [15:0] R_USP = 16'hFE00, R_SSP = 16'h1200;

  logic clk = 1'b0, rstN = 1'b0;
  logic fetchStart = 1'b0, irqValid = 1'b0, rtiReq = 1'b0;
  logic [2:0] irqLevel = '0;
  logic [7:0] irqVector = '0;
  logic ackPulse, busy, memWrEn, memRdEn;
  logic [15:0] memAddr, memWData, memRData, pcOut, psrOut, spOut, savedUspOut, savedSspOut;
  logic [15:0] mem [0:1023];
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  function automatic int idx(input logic [15:0] a);
    return {a[12], a[8:0]};
  endfunction
  function automatic logic [15:0] handler(input int v);
    return 16'h4000 + 16'(v * 5);
  endfunction

  assign memRData = mem[idx(memAddr)];
  always @(posedge clk) if (memWrEn) mem[idx(memAddr)] <= memWData;

  irq_seq_top #(.RESET_PC(R_PC), .RESET_PSR(R_PSR), .RESET_USP(R_USP), .RESET_SSP(R_SSP)) dut_i (
    .clk(clk), .rstN(rstN), .fetchStart(fetchStart), .irqValid(irqValid),
    .irqLevel(irqLevel), .irqVector(irqVector), .rtiReq(rtiReq),
    .ackPulse(ackPulse), .busy(busy), .memAddr(memAddr), .memWrEn(memWrEn),
    .memRdEn(memRdEn), .memWData(memWData), .memRData(memRData),
    .pcOut(pcOut), .psrOut(psrOut), .spOut(spOut),
    .savedUspOut(savedUspOut), .savedSspOut(savedSspOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Accepted entry: drives the request and waits until the sequence is done.
  task automatic enter(input logic [2:0] lvl, input logic [7:0] vec);
    fetchStart = 1'b1; irqValid = 1'b1; irqLevel = lvl; irqVector = vec;
    @(negedge clk);
    fetchStart = 1'b0; irqValid = 1'b0;
    chk("R3 ack", {15'd0, ackPulse}, 16'd1);
    @(negedge clk);
    irqVector = ~vec;
    chk("R3 ack single", {15'd0, ackPulse}, 16'd0);
    chk("R8 busy mid", {15'd0, busy}, 16'd1);
    repeat (3) @(negedge clk);
    chk("R8 busy done", {15'd0, busy}, 16'd0);
  endtask

  task automatic leave();
    rtiReq = 1'b1;
    @(negedge clk);
    rtiReq = 1'b0;
    chk("R9 busy", {15'd0, busy}, 16'd1);
    repeat (3) @(negedge clk);
    chk("R9 busy done", {15'd0, busy}, 16'd0);
  endtask

  // Refused request held for two cycles.
  task automatic refused(input string req, input logic fs, input logic [2:0] lvl);
    logic [15:0] pc0, sp0, psr0;
    pc0 = pcOut; sp0 = spOut; psr0 = psrOut;
    fetchStart = fs; irqValid = 1'b1; irqLevel = lvl;
    repeat (2) begin
      @(negedge clk);
      chk(req, {15'd0, busy}, 16'd0);
    end
    fetchStart = 1'b0; irqValid = 1'b0;
    chk(req, pcOut, pc0); chk(req, spOut, sp0); chk(req, psrOut, psr0);
  endtask

  initial begin
    for (int v = 0; v < 1024; v++) mem[v] = '0;
    for (int v = 0; v < 256; v++) mem[idx(16'h0100 + 16'(v))] = handler(v);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1
    chk("R1 pc", pcOut, R_PC); chk("R1 psr", psrOut, R_PSR);
    chk("R1 sp", spOut, R_USP); chk("R1 ssp", savedSspOut, R_SSP);
    chk("R1 usp", savedUspOut, 16'h0); chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 ack", {15'd0, ackPulse}, 16'd0);
    // R2: no boundary, and level not above priority 0
    refused("R2 no fetchStart", 1'b0, 3'd5);
    refused("R2 level0", 1'b1, 3'd0);

    // Sweep user-mode entry and return over levels and vectors
    for (int l = 1; l < 8; l++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] v;
        v = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h5A : 8'hFF;
        enter(3'(l), v);
        chk("R4 usp", savedUspOut, R_USP);
        chk("R6 sp", spOut, R_SSP - 16'd2);
        chk("R6 psr slot", mem[idx(R_SSP - 16'd1)], R_PSR);
        chk("R6 pc slot", mem[idx(R_SSP - 16'd2)], R_PC);
        chk("R7 psr", psrOut, {5'd0, 3'(l), 8'd0});
        chk("R8 pc", pcOut, handler(v));
        leave();
        chk("R9 pc", pcOut, R_PC);
        chk("R9 psr", psrOut, R_PSR);
        chk("R10 sp", spOut, R_USP);
        chk("R10 ssp", savedSspOut, R_SSP);
      end
    end

    // Nested: supervisor-mode entry without swap
    enter(3'd3, 8'h22);
    refused("R2 lower level", 1'b1, 3'd2);
    refused("R2 equal level", 1'b1, 3'd3);
    enter(3'd6, 8'h33);
    chk("R5 usp kept", savedUspOut, R_USP);
    chk("R5 sp", spOut, R_SSP - 16'd4);
    chk("R6 nested psr slot", mem[idx(R_SSP - 16'd3)], 16'h0300);
    chk("R6 nested pc slot", mem[idx(R_SSP - 16'd4)], handler(8'h22));
    chk("R7 nested psr", psrOut, 16'h0600);
    chk("R8 nested pc", pcOut, handler(8'h33));
    leave();
    chk("R10 no swap sp", spOut, R_SSP - 16'd2);
    chk("R10 no swap ssp", savedSspOut, R_SSP);
    chk("R9 inner pc", pcOut, handler(8'h22));
    chk("R9 inner psr", psrOut, 16'h0300);
    leave();
    chk("R10 outer sp", spOut, R_USP);
    chk("R9 outer psr", psrOut, R_PSR);
    chk("R9 outer pc", pcOut, R_PC);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule